// File: doc/BRIEF.md
# Slice Assembler with Line Scanout

This block collects decoded 8x8 sample blocks of a 4:2:0 picture and rebuilds them into one horizontal slice of video, sixteen lines tall and `2**MB_LOG2` macroblocks wide. Blocks arrive one sample per accepted cycle on a ready/valid input. Each macroblock is sent as four luma blocks (top-left, top-right, bottom-left, bottom-right), then its blue-difference block, then its red-difference block. Every block carries 64 samples in raster order. Once a whole slice is present, it is sent out as sixteen 4:2:2 lines. Each line is wrapped in CCIR-656 style timing codes: a start-of-active-video code before the samples and an end-of-active-video code after them.

Luma and chroma each have a single buffer that holds exactly one slice. The buffer is not doubled. Instead, the mapping from sample index to memory address changes with every slice. Each new mapping is the previous one composed with the fixed bit permutation that relates the block write order to the line read order. As a result, the next slice's samples land, in their arrival order, in the same cells the current slice frees in its read order. The next slice can therefore be written while the current one is still being read out.

Two state machines drive the block. The writer steps WR_LUMA -> WR_CB -> WR_CR -> WR_LUMA, moving on after the 64th sample of each block; the fourth luma block ends WR_LUMA. The reader steps RD_IDLE -> RD_SAV (a slice is complete) -> RD_ACT (four code bytes sent) -> RD_EAV (last active byte) -> RD_SAV (next line). After line 15 the reader goes to RD_SAV if another slice is already complete, and otherwise to RD_IDLE.

Top module: `slice_assembler`

## Requirements
- R1: After reset, `line_valid` is low and `blk_ready` is high.
- R2: At active byte position p of output line L, an odd p carries luma sample column (p-1)/2 of line L. Samples are placed according to the input order: block index {by,bx} gives TL=0, TR=1, BL=2, BR=3, and each block is 64 samples in raster order.
- R3: At an even active position p, the byte is chroma column p/4 of chroma row L/2. It is blue-difference when p mod 4 = 0 and red-difference when p mod 4 = 2. Each chroma row therefore appears on two consecutive lines.
- R4: Every line begins with the four bytes FF 00 00 80, which is the start code with XY = {1,F,V,H,V^H,F^H,F^V,F^V^H}, F=V=0 and H=0.
- R5: Every line ends with FF 00 00 9D, the same code with H=1, and `line_valid` only falls directly after such an end code.
- R6: A line is 8 + 32*2**MB_LOG2 bytes long. The 16 lines of a slice come out in order 0 to 15, with `line_valid` held high from the first byte of line 0 to the last byte of line 15.
- R7: Readout of a slice starts only after the last sample of that slice has been accepted.
- R8: Samples of the next slice are accepted while the previous slice is still being read out, using a single slice buffer.
- R9: `blk_ready` is high whenever no complete slice awaits readout. It is low only while the cell the next sample maps to has not yet been read.
- R10: The output data stays correct for every slice after the first, as the address mapping rotates from slice to slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_valid | input | 1 | Input sample valid |
| blk_ready | output | 1 | Input sample can be accepted this cycle |
| blk_data | input | DW | Input sample, in macroblock/block/raster order |
| line_valid | output | 1 | Output byte valid; never stalls |
| line_data | output | DW | Output byte: timing codes and Cb,Y,Cr,Y samples |

## Verification
The hardest situation to reach is the writer chasing the reader inside the single buffer. Here `blk_ready` falls and rises sample by sample as luma and chroma cells free up, and chroma frees only on the second line of each row pair. The stimulus reaches it by driving four slices with `blk_valid` held high. Input then outruns readout, so every slice after the first is written into cells freed moments earlier under a mapping rotated once more. Two later slices arrive sparsely, so the reader runs dry and must restart from its idle state.

// File: rtl/sa_pkg.sv
package sa_pkg;

    typedef enum logic [1:0] {RD_IDLE, RD_SAV, RD_ACT, RD_EAV} rd_state_t;
    typedef enum logic [1:0] {WR_LUMA, WR_CB, WR_CR} wr_state_t;
    typedef enum logic [1:0] {SRC_CODE, SRC_LUMA, SRC_CHROMA} src_t;

    // progressive slice stream inside the active picture
    localparam logic FIELD_BIT  = 1'b0;
    localparam logic VBLANK_BIT = 1'b0;

    function automatic logic [7:0] xy_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // byte k of a timing code; h selects end (1) or start (0)
    function automatic logic [7:0] code_byte(input logic [1:0] k, input logic h);
        logic [7:0] b;
        unique case (k)
            2'd0:    b = 8'hFF;
            2'd1:    b = 8'h00;
            2'd2:    b = 8'h00;
            default: b = xy_word(FIELD_BIT, VBLANK_BIT, h);
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sa_ram.sv
module sa_ram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/sa_rotator.sv
module sa_rotator #(
    parameter int MB_LOG2 = 1,
    parameter int IDX_W   = 9,
    parameter bit LUMA    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] wr_addr,
    output logic [IDX_W-1:0] rd_addr
);
    localparam int PW   = $clog2(IDX_W);
    localparam int QLEN = 1 << PW;

    // read-order bit that feeds write-order bit i
    function automatic int src_bit(input int i);
        int r;
        if (LUMA) begin
            if (i < 3)       r = i;
            else if (i < 6)  r = 4 + MB_LOG2 + (i - 3);
            else if (i == 6) r = 3;
            else if (i == 7) r = 7 + MB_LOG2;
            else             r = 4 + (i - 8);
        end else begin
            if (i < 3)       r = i + 1;
            else if (i < 6)  r = 4 + MB_LOG2 + (i - 3);
            else if (i == 6) r = 0;
            else             r = 4 + (i - 7);
        end
        return r;
    endfunction

    logic [PW-1:0] qtab    [QLEN];
    logic [PW-1:0] wr_perm [IDX_W];
    logic [PW-1:0] rd_perm [IDX_W];

    generate
        if (LUMA) begin : g_luma_q
            always_comb begin
                for (int i = 0; i < QLEN; i++)
                    qtab[i] = (i < IDX_W) ? PW'(src_bit(i)) : '0;
            end
        end else begin : g_chroma_q
            always_comb begin
                for (int i = 0; i < QLEN; i++)
                    qtab[i] = (i < IDX_W) ? PW'(src_bit(i)) : '0;
            end
        end
    endgenerate

    // writer takes the next mapping, reader keeps the one its slice used
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < IDX_W; j++) begin
                wr_perm[j] <= PW'(j);
                rd_perm[j] <= PW'(j);
            end
        end else if (advance) begin
            for (int j = 0; j < IDX_W; j++) begin
                rd_perm[j] <= wr_perm[j];
                wr_perm[j] <= qtab[wr_perm[j]];
            end
        end
    end

    genvar j;
    generate
        for (j = 0; j < IDX_W; j++) begin : g_bit
            assign wr_addr[j] = wr_idx[wr_perm[j]];
            assign rd_addr[j] = rd_idx[qtab[rd_perm[j]]];
        end
    endgenerate

    logic [IDX_W-1:0] used_w, used_r;
    always_comb begin
        used_w = '0;
        used_r = '0;
        for (int k = 0; k < IDX_W; k++) begin
            used_w[wr_perm[k]] = 1'b1;
            used_r[rd_perm[k]] = 1'b1;
        end
    end

    AST_PERM_BIJECTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(used_w) == IDX_W) && ($countones(used_r) == IDX_W)); // R8

endmodule

// File: rtl/sa_writer.sv
module sa_writer
    import sa_pkg::*;
#(
    parameter int MB_LOG2 = 1,
    parameter int DW      = 8,
    localparam int LB     = MB_LOG2 + 8,
    localparam int CB     = MB_LOG2 + 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_valid,
    input  logic [DW-1:0] blk_data,
    output logic          blk_ready,
    input  logic          slice_full,
    input  logic [LB:0]   luma_free,
    input  logic [CB:0]   chroma_free,
    output logic          l_we,
    output logic [LB-1:0] l_idx,
    output logic          c_we,
    output logic [CB-1:0] c_idx,
    output logic [DW-1:0] wr_data,
    output logic          wr_done
);
    wr_state_t          st, st_nx;
    logic [MB_LOG2-1:0] mb;
    logic [1:0]         lblk;
    logic [5:0]         pix;
    logic               fire, last_pix, last_mb;

    assign fire     = blk_valid && blk_ready;
    assign last_pix = (pix == 6'd63);
    assign last_mb  = (mb == '1);

    always_comb begin
        st_nx = st;
        unique case (st)
            WR_LUMA: if (fire && last_pix && lblk == 2'd3) st_nx = WR_CB;
            WR_CB:   if (fire && last_pix)                 st_nx = WR_CR;
            WR_CR:   if (fire && last_pix)                 st_nx = WR_LUMA;
            default:                                       st_nx = WR_LUMA;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WR_LUMA;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mb   <= '0;
            lblk <= '0;
            pix  <= '0;
        end else if (fire) begin
            pix <= pix + 6'd1;
            if (last_pix) begin
                if (st == WR_LUMA) lblk <= lblk + 2'd1;
                if (st == WR_CR)   mb   <= mb + 1'b1;
            end
        end
    end

    always_comb begin
        l_idx   = {mb, lblk, pix};
        c_idx   = {mb, (st == WR_CR), pix};
        wr_data = blk_data;
        if (st == WR_LUMA)
            blk_ready = !slice_full || ({1'b0, l_idx} < luma_free);
        else
            blk_ready = !slice_full || ({1'b0, c_idx} < chroma_free);
        l_we    = fire && (st == WR_LUMA);
        c_we    = fire && (st != WR_LUMA);
        wr_done = fire && (st == WR_CR) && last_pix && last_mb;
    end

    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !slice_full |-> blk_ready); // R9

endmodule

// File: rtl/sa_reader.sv
module sa_reader
    import sa_pkg::*;
#(
    parameter int MB_LOG2  = 1,
    localparam int LB      = MB_LOG2 + 8,
    localparam int CB      = MB_LOG2 + 7,
    localparam int ACT_LEN = 32 << MB_LOG2,
    localparam int POS_W   = MB_LOG2 + 5,
    localparam int CP_W    = MB_LOG2 + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slice_full,
    output logic [LB:0]   luma_free,
    output logic [CB:0]   chroma_free,
    output logic          l_re,
    output logic [LB-1:0] l_idx,
    output logic          c_re,
    output logic [CB-1:0] c_idx,
    output logic          issue,
    output src_t          src,
    output logic [7:0]    code,
    output logic          rd_release
);
    rd_state_t        st, st_nx;
    logic [1:0]       kcnt;
    logic [POS_W-1:0] pos;
    logic [3:0]       line;
    logic [LB:0]      lcnt;
    logic [CP_W-1:0]  cpos;
    logic [CB:0]      cfree;
    logic             pos_last, code_last, line_last;

    assign pos_last  = (pos == POS_W'(ACT_LEN - 1));
    assign code_last = (kcnt == 2'd3);
    assign line_last = (line == 4'd15);

    always_comb begin
        st_nx = st;
        unique case (st)
            RD_IDLE: if (slice_full) st_nx = RD_SAV;
            RD_SAV:  if (code_last)  st_nx = RD_ACT;
            RD_ACT:  if (pos_last)   st_nx = RD_EAV;
            RD_EAV:  if (code_last)
                         st_nx = (!line_last || slice_full) ? RD_SAV : RD_IDLE;
            default:                 st_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RD_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kcnt  <= '0;
            pos   <= '0;
            line  <= '0;
            lcnt  <= '0;
            cpos  <= '0;
            cfree <= '0;
        end else begin
            unique case (st)
                RD_SAV: kcnt <= kcnt + 2'd1;
                RD_EAV: begin
                    kcnt <= kcnt + 2'd1;
                    if (code_last) line <= line + 4'd1;
                end
                RD_ACT: begin
                    pos <= pos + 1'b1;
                    if (pos[0]) begin
                        lcnt <= lcnt + 1'b1;
                    end else begin
                        cpos <= cpos + 1'b1;
                        if (line[0]) cfree <= cfree + 1'b1;
                    end
                    if (rd_release) begin
                        lcnt  <= '0;
                        cfree <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        issue       = (st != RD_IDLE);
        code        = code_byte(kcnt, st == RD_EAV);
        l_re        = (st == RD_ACT) && pos[0];
        c_re        = (st == RD_ACT) && !pos[0];
        l_idx       = lcnt[LB-1:0];
        c_idx       = {line[3:1], cpos};
        rd_release  = (st == RD_ACT) && pos_last && line_last;
        luma_free   = lcnt;
        chroma_free = cfree;
        if (st == RD_ACT) src = pos[0] ? SRC_LUMA : SRC_CHROMA;
        else              src = SRC_CODE;
    end

    AST_IDLE_AFTER_LAST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RD_IDLE && $past(st) == RD_EAV) |-> $past(line) == 4'd15); // R6

endmodule

// File: rtl/slice_assembler.sv
module slice_assembler
    import sa_pkg::*;
#(
    parameter int MB_LOG2 = 1,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_valid,
    output logic          blk_ready,
    input  logic [DW-1:0] blk_data,
    output logic          line_valid,
    output logic [DW-1:0] line_data
);
    localparam int LB = MB_LOG2 + 8;
    localparam int CB = MB_LOG2 + 7;

    logic          full;
    logic          wr_done, rd_release;
    logic [LB:0]   luma_free;
    logic [CB:0]   chroma_free;
    logic          l_we, c_we, l_re, c_re;
    logic [LB-1:0] lw_idx, lr_idx, lw_addr, lr_addr;
    logic [CB-1:0] cw_idx, cr_idx, cw_addr, cr_addr;
    logic [DW-1:0] wr_data, l_rdata, c_rdata;
    logic          issue;
    src_t          src, src_q;
    logic [7:0]    code, code_q;
    logic          vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          full <= 1'b0;
        else if (wr_done)    full <= 1'b1;
        else if (rd_release) full <= 1'b0;
    end

    sa_writer #(.MB_LOG2(MB_LOG2), .DW(DW)) u_writer (
        .clk(clk), .rst_n(rst_n),
        .blk_valid(blk_valid), .blk_data(blk_data), .blk_ready(blk_ready),
        .slice_full(full), .luma_free(luma_free), .chroma_free(chroma_free),
        .l_we(l_we), .l_idx(lw_idx), .c_we(c_we), .c_idx(cw_idx),
        .wr_data(wr_data), .wr_done(wr_done)
    );

    sa_reader #(.MB_LOG2(MB_LOG2)) u_reader (
        .clk(clk), .rst_n(rst_n), .slice_full(full),
        .luma_free(luma_free), .chroma_free(chroma_free),
        .l_re(l_re), .l_idx(lr_idx), .c_re(c_re), .c_idx(cr_idx),
        .issue(issue), .src(src), .code(code), .rd_release(rd_release)
    );

    sa_rotator #(.MB_LOG2(MB_LOG2), .IDX_W(LB), .LUMA(1'b1)) u_rot_luma (
        .clk(clk), .rst_n(rst_n), .advance(wr_done),
        .wr_idx(lw_idx), .rd_idx(lr_idx), .wr_addr(lw_addr), .rd_addr(lr_addr)
    );

    sa_rotator #(.MB_LOG2(MB_LOG2), .IDX_W(CB), .LUMA(1'b0)) u_rot_chroma (
        .clk(clk), .rst_n(rst_n), .advance(wr_done),
        .wr_idx(cw_idx), .rd_idx(cr_idx), .wr_addr(cw_addr), .rd_addr(cr_addr)
    );

    sa_ram #(.AW(LB), .DW(DW)) u_ram_luma (
        .clk(clk), .we(l_we), .waddr(lw_addr), .wdata(wr_data),
        .re(l_re), .raddr(lr_addr), .rdata(l_rdata)
    );

    sa_ram #(.AW(CB), .DW(DW)) u_ram_chroma (
        .clk(clk), .we(c_we), .waddr(cw_addr), .wdata(wr_data),
        .re(c_re), .raddr(cr_addr), .rdata(c_rdata)
    );

    // output stage lines codes up with the one-cycle memory read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            src_q  <= SRC_CODE;
            code_q <= '0;
        end else begin
            vld_q  <= issue;
            src_q  <= src;
            code_q <= code;
        end
    end

    always_comb begin
        line_valid = vld_q;
        unique case (src_q)
            SRC_CODE: line_data = DW'(code_q);
            SRC_LUMA: line_data = l_rdata;
            default:  line_data = c_rdata;
        endcase
    end

    AST_NO_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_done && rd_release)); // R8
    AST_LUMA_WRITE_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
        (l_we && full) |-> ({1'b0, lw_idx} < luma_free)); // R9
    AST_CHROMA_WRITE_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
        (c_we && full) |-> ({1'b0, cw_idx} < chroma_free)); // R9
    AST_STOP_AFTER_EAV: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_valid) |-> ($past(line_data) == DW'(xy_word(FIELD_BIT, VBLANK_BIT, 1'b1)))); // R5

endmodule

// File: tb/slice_assembler_test.sv
module slice_assembler_test;
    localparam int CLK_PERIOD = 10;
    localparam int MB_LOG2    = 1;
    localparam int MBW        = 1 << MB_LOG2;
    localparam int SL         = MBW * 384;
    localparam int NS         = 6;
    localparam int FLOOD      = 4;
    localparam int LINE_LEN   = 8 + 32 * MBW;
    localparam int LIMIT      = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_valid = 1'b0;
    logic [7:0] blk_data = 8'h00;
    logic       blk_ready, line_valid;
    logic [7:0] line_data;

    slice_assembler #(.MB_LOG2(MB_LOG2), .DW(8)) uut (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
        .blk_data(blk_data), .line_valid(line_valid), .line_data(line_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int         vectors = 0, errors = 0;
    logic [7:0] in_mem [NS][SL];
    int         t_first_acc [NS];
    int         t_last_acc [NS];
    int         t_last_out [NS];
    bit         mon_done = 1'b0;
    bit         data_ready = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] exp_active(input int s, input int line, input int p);
        int idx;
        if (p % 2 == 1) begin
            int col = p / 2;
            idx = (col / 16) * 384 + ((line / 8) * 2 + (col / 8) % 2) * 64
                + (line % 8) * 8 + col % 8;
        end else begin
            int cx = p / 4;
            idx = (cx / 8) * 384 + (4 + (p / 2) % 2) * 64 + (line / 2) * 8 + cx % 8;
        end
        return in_mem[s][idx];
    endfunction

    function automatic logic [7:0] exp_code(input int k, input bit eav);
        if (k == 0) return 8'hFF;
        if (k < 3)  return 8'h00;
        return eav ? 8'h9D : 8'h80;
    endfunction

    // driver: four flooding slices, then two sparse ones
    initial begin
        void'($urandom(32'd5171));
        for (int s = 0; s < NS; s++) begin
            t_first_acc[s] = -1;
            t_last_acc[s]  = -1;
            t_last_out[s]  = -1;
            for (int i = 0; i < SL; i++) in_mem[s][i] = 8'(1 + $urandom % 254);
        end
        data_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(line_valid == 1'b0, "R1 line_valid", int'(line_valid), 0);
        check(blk_ready == 1'b1, "R1 blk_ready", int'(blk_ready), 1);
        for (int s = 0; s < NS; s++) begin
            for (int i = 0; i < SL; ) begin
                @(negedge clk);
                blk_valid = (s < FLOOD) ? 1'b1 : (($urandom % 10) < 3);
                blk_data  = in_mem[s][i];
                #1;
                if (s == 0) check(blk_ready == 1'b1, "R9 ready during first fill", int'(blk_ready), 1);
                if (blk_valid && blk_ready) begin
                    if (i == 0)      t_first_acc[s] = cyc;
                    if (i == SL - 1) t_last_acc[s]  = cyc;
                    i++;
                end
            end
        end
        @(negedge clk);
        blk_valid = 1'b0;
    end

    // monitor: every output byte against the expected stream
    initial begin
        int  s = 0, line = 0, bc = 0;
        bit  in_slice = 1'b0;
        wait (rst_n && data_ready);
        while (s < NS) begin
            @(negedge clk);
            #2;
            if (in_slice) check(line_valid == 1'b1, "R6 continuous slice", int'(line_valid), 1);
            if (line_valid) begin
                logic [7:0] e;
                string      req;
                if (bc == 0 && line == 0)
                    check(t_last_acc[s] >= 0 && cyc > t_last_acc[s], "R7 start after fill",
                          cyc, t_last_acc[s]);
                in_slice = 1'b1;
                if (bc < 4) begin
                    e = exp_code(bc, 1'b0);
                    req = "R4 start code";
                end else if (bc >= LINE_LEN - 4) begin
                    e = exp_code(bc - (LINE_LEN - 4), 1'b1);
                    req = "R5 end code";
                end else begin
                    e = exp_active(s, line, bc - 4);
                    if ((bc - 4) % 2 == 1) req = (s == 0) ? "R2 luma" : "R10 luma";
                    else                   req = (s == 0) ? "R3 chroma" : "R10 chroma";
                end
                check(line_data == e, req, int'(line_data), int'(e));
                bc++;
                if (bc == LINE_LEN) begin
                    bc = 0;
                    line++;
                    if (line == 16) begin
                        line = 0;
                        t_last_out[s] = cyc;
                        s++;
                        in_slice = 1'b0;
                    end
                end
            end
        end
        mon_done = 1'b1;
    end

    initial begin
        wait (rst_n);
        while (!mon_done && cyc < LIMIT) @(negedge clk);
        if (!mon_done) check(1'b0, "WATCHDOG", cyc, LIMIT);
        for (int s = 0; s < FLOOD - 1; s++)
            check(t_first_acc[s + 1] >= 0 && t_first_acc[s + 1] < t_last_out[s],
                  "R8 overlap of write and readout", t_first_acc[s + 1], t_last_out[s]);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule